// File: doc/BRIEF.md
# Receive Frame Queue with Control and Status Word

This block holds received frames for a CAN-style controller until software takes them. The receive path offers one complete frame per cycle on a push strobe. Each frame is stored as an opaque payload word in a small circular buffer. The oldest stored frame is always shown on a head port, together with a valid flag.

Software works through one 32-bit memory-mapped word. Reading it returns the number of pending frames, a sticky full flag, a sticky overrun flag and a pending release request. Software releases the head frame by writing 1 to the request bit. The hardware completes the release on the next clock and clears the bit. Software clears each sticky flag by writing 1 to it.

Top module: `rxfifo_stat`

## Requirements
- R1: After a synchronous reset the status word reads 0, no frame is pending and `head_valid` is low.
- R2: Bits 1:0 of the status word (byte offset 0x0C) give the pending frame count, 0 to 3. An accepted push adds 1 to it.
- R3: `head_frame` shows the oldest stored frame, and frames leave in arrival order. `head_valid` is high exactly when the count is nonzero. A push into a non-empty queue leaves the head unchanged.
- R4: Bit 3 is the full flag. It is set when an accepted push leaves 3 frames stored. It stays set after frames are released, and is cleared by writing 1 to bit 3. Writing 0 to it has no effect.
- R5: Bit 4 is the overrun flag. A push while 3 frames are stored and no release completes is discarded. The stored frames are kept, and bit 4 is set. Writing 1 to bit 4 clears it.
- R6: Writing 1 to bit 5 sets the release request, which reads 1 for exactly one cycle. On the following clock the head frame is removed, the count drops by 1 and bit 5 clears.
- R7: When a push and a completing release meet on a non-empty queue, the count stays unchanged and no frame is lost. This includes a queue holding 3 frames, where the full flag is set again.
- R8: A release request on an empty queue clears itself and changes neither the count nor any flag.
- R9: Bits 31:6 and bit 2 read 0 and ignore writes. Reads at any address other than 0x0C return 0.
- R10: A write that is not a full word (byte enables other than 4'b1111), or that targets another address, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Offers `rx_frame` for storage this cycle |
| rx_frame | input | PAYLOAD_W | Frame payload to store |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| head_frame | output | PAYLOAD_W | Oldest stored frame |
| head_valid | output | 1 | High when at least one frame is stored |

## Verification
The bound checker runs the cycle-to-cycle rules on every clock:
- count steps on push, release and a simultaneous push and release;
- the sticky flags hold unless a clearing write arrives;
- the release bit clears after one cycle;
- the head holds steady under pushes;
- the reserved bits read zero;
- stray writes change no state.

Only the bench scenarios show that frames come out in arrival order and that a discarded frame never appears. They also show that the right payload moves to the head after each release and that full and overrun readback hold across a long sequence of pushes and clears.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_FULL   = 3;
  localparam int BIT_OVR    = 4;
  localparam int BIT_DEQ    = 5;

  typedef struct packed {
    logic deq_set;
    logic full_clr;
    logic ovr_clr;
  } sw_cmd_t;
endpackage

// File: rtl/rxfifo_store.sv
module rxfifo_store #(
  parameter int DEPTH     = 3,
  parameter int PAYLOAD_W = 64,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [PTR_W-1:0]     wr_ptr,
  input  logic [PAYLOAD_W-1:0] wr_data,
  input  logic [PTR_W-1:0]     rd_ptr,
  output logic [PAYLOAD_W-1:0] rd_data
);
  logic [PAYLOAD_W-1:0] mem [DEPTH];

  // No reset on the array so it maps onto RAM resources
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int DEPTH  = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  sw_cmd_t          cmd,
  output logic [CNT_W-1:0] cnt_q,
  output logic             full_q,
  output logic             ovr_q,
  output logic             deq_q,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic             pop, accept, ovr_ev;
  logic [CNT_W-1:0] cnt_n;
  logic [PTR_W-1:0] wr_inc, rd_inc;

  assign pop    = deq_q && (cnt_q != '0);
  assign accept = push && ((cnt_q != CNT_MAX) || pop);
  assign ovr_ev = push && !accept;
  assign wr_en  = accept;

  always_comb begin
    cnt_n = cnt_q;
    if (accept && !pop)      cnt_n = cnt_q + CNT_W'(1);
    else if (pop && !accept) cnt_n = cnt_q - CNT_W'(1);
  end

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_inc = wr_ptr + PTR_W'(1);
      assign rd_inc = rd_ptr + PTR_W'(1);
    end else begin : g_wrap
      assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      deq_q  <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      cnt_q  <= cnt_n;
      // Hardware set wins over a clearing write in the same cycle
      full_q <= (accept && cnt_n == CNT_MAX) || (full_q && !cmd.full_clr);
      ovr_q  <= ovr_ev || (ovr_q && !cmd.ovr_clr);
      // A request lives for one cycle: it is served or dropped on the next edge
      deq_q  <= cmd.deq_set;
      if (accept) wr_ptr <= wr_inc;
      if (pop)    rd_ptr <= rd_inc;
    end
  end
endmodule

// File: rtl/rxfifo_regif.sv
module rxfifo_regif
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W            = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C,
  parameter int CNT_W             = 2
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              full,
  input  logic              ovr,
  input  logic              deq,
  output sw_cmd_t           cmd,
  output logic [REG_W-1:0]  bus_rdata
);
  logic hit, wr_hit;
  logic [REG_W-1:0] status;

  assign hit    = (bus_addr == REG_OFS);
  assign wr_hit = hit && bus_wr && (bus_be == 4'hF);

  assign cmd.deq_set  = wr_hit && bus_wdata[BIT_DEQ];
  assign cmd.full_clr = wr_hit && bus_wdata[BIT_FULL];
  assign cmd.ovr_clr  = wr_hit && bus_wdata[BIT_OVR];

  always_comb begin
    status               = '0;
    status[CNT_W-1:0]    = cnt;
    status[BIT_FULL]     = full;
    status[BIT_OVR]      = ovr;
    status[BIT_DEQ]      = deq;
  end

  assign bus_rdata = hit ? status : '0;
endmodule

// File: rtl/rxfifo_stat.sv
module rxfifo_stat
  import rxfifo_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int PAYLOAD_W = 64,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_push,
  input  logic [PAYLOAD_W-1:0] rx_frame,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [PAYLOAD_W-1:0] head_frame,
  output logic                 head_valid
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  sw_cmd_t          cmd;
  logic [CNT_W-1:0] cnt_w;
  logic             full_w, ovr_w, deq_w, wr_en;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  rxfifo_regif #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .CNT_W(CNT_W)) u_regif (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .cnt(cnt_w), .full(full_w), .ovr(ovr_w), .deq(deq_w),
    .cmd(cmd), .bus_rdata(bus_rdata)
  );

  rxfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push(rx_push), .cmd(cmd),
    .cnt_q(cnt_w), .full_q(full_w), .ovr_q(ovr_w), .deq_q(deq_w),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  rxfifo_store #(.DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(rx_frame),
    .rd_ptr(rd_ptr), .rd_data(head_frame)
  );

  assign head_valid = (cnt_w != '0);
endmodule

// File: rtl/rxfifo_stat_chk.sv
module rxfifo_stat_chk #(
  parameter int DEPTH     = 3,
  parameter int PAYLOAD_W = 64,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_push,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [PAYLOAD_W-1:0] head_frame,
  input logic                 head_valid,
  input logic [CNT_W-1:0]     cnt,
  input logic                 full,
  input logic                 ovr,
  input logic                 deq
);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);
  logic whit;
  assign whit = bus_wr && (bus_be == 4'hF) && (bus_addr == REG_OFS);

  p_push_inc_r2: assert property (@(posedge clk) disable iff (rst)
    rx_push && cnt != CMAX && !deq |=> cnt == $past(cnt) + CNT_W'(1));
  p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
    head_valid && !deq |=> $stable(head_frame) && head_valid);
  p_full_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    full && !(whit && bus_wdata[3]) |=> full);
  p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
    rx_push && cnt == CMAX && !deq |=> ovr && cnt == CMAX);
  p_deq_once_r6: assert property (@(posedge clk) disable iff (rst)
    deq && !(whit && bus_wdata[5]) |=> !deq);
  p_deq_pop_r6: assert property (@(posedge clk) disable iff (rst)
    deq && cnt != '0 && !rx_push |=> cnt == $past(cnt) - CNT_W'(1));
  p_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    deq && cnt != '0 && rx_push |=> cnt == $past(cnt));
  p_empty_deq_r8: assert property (@(posedge clk) disable iff (rst)
    deq && cnt == '0 && !rx_push && !whit |=> cnt == '0 && full == $past(full) && ovr == $past(ovr));
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:6] == '0 && !bus_rdata[2]);
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !whit && !rx_push && !deq |=> $stable({cnt, full, ovr, deq}));
endmodule

bind rxfifo_stat rxfifo_stat_chk #(
  .DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)
) u_chk (
  .clk(clk), .rst(rst), .rx_push(rx_push), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .head_frame(head_frame), .head_valid(head_valid),
  .cnt(cnt_w), .full(full_w), .ovr(ovr_w), .deq(deq_w)
);

// File: tb/rxfifo_stat_bench.sv
module rxfifo_stat_bench;
  localparam int  PW  = 64;
  localparam time CLK = 5ns;

  logic          clk = 0, rst = 1;
  logic          rx_push = 0;
  logic [PW-1:0] rx_frame = '0;
  logic [7:0]    bus_addr = 8'h0C;
  logic          bus_wr = 0;
  logic [3:0]    bus_be = 4'hF;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [PW-1:0] head_frame;
  logic          head_valid;

  int checks = 0, fails = 0;
  logic [PW-1:0] exp_q [$];

  always #(CLK/2) clk = ~clk;

  rxfifo_stat u_rxfifo_stat (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rx_frame(rx_frame),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .head_frame(head_frame), .head_valid(head_valid)
  );

  task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: inputs already driven at a falling edge, advance to the next one
  task automatic step();
    @(negedge clk);
    rx_push = 0; bus_wr = 0; bus_be = 4'hF; bus_addr = 8'h0C;
    #1;
  endtask

  function automatic logic [31:0] status();
    return bus_rdata;
  endfunction

  // Driver: pushes a frame and records it as expected if room remains
  task automatic push_frame(logic [PW-1:0] d);
    rx_push = 1; rx_frame = d;
    if (exp_q.size() < 3) exp_q.push_back(d);
    step();
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    step();
  endtask

  // Monitor: compares the head against the scoreboard before each release
  task automatic monitor_head(string tag);
    chk(tag, head_frame, exp_q[0]);
  endtask

  task automatic dequeue(string tag);
    monitor_head(tag);
    wr(8'h0C, 4'hF, 32'h20);
    step();
    void'(exp_q.pop_front());
  endtask

  task automatic dequeue_with_push(string tag, logic [PW-1:0] d);
    monitor_head(tag);
    wr(8'h0C, 4'hF, 32'h20);
    rx_push = 1; rx_frame = d;
    step();
    void'(exp_q.pop_front());
    exp_q.push_back(d);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; #1;
    chk("R1 status", status(), 0);
    chk("R1 head_valid", head_valid, 0);

    push_frame(64'hA0A0);
    chk("R2 count 1", status(), 32'h1);
    chk("R3 valid", head_valid, 1);
    chk("R3 head A", head_frame, 64'hA0A0);
    push_frame(64'hB1B1);
    push_frame(64'hC2C2);
    chk("R4 full set", status(), 32'h0B);
    chk("R3 head kept", head_frame, 64'hA0A0);

    push_frame(64'hD3D3);
    chk("R5 overrun", status(), 32'h1B);
    chk("R5 frames kept", head_frame, 64'hA0A0);

    wr(8'h0C, 4'hF, 32'h0);
    chk("R4 write zero", status(), 32'h1B);
    wr(8'h0C, 4'h3, 32'h38);
    chk("R10 partial write", status(), 32'h1B);
    wr(8'h08, 4'hF, 32'h38);
    chk("R10 other address", status(), 32'h1B);

    monitor_head("R3 order A");
    wr(8'h0C, 4'hF, 32'h20);
    chk("R6 request visible", status(), 32'h3B);
    step();
    void'(exp_q.pop_front());
    chk("R6 released", status(), 32'h1A);
    chk("R4 full sticky", status() & 32'h8, 32'h8);

    wr(8'h0C, 4'hF, 32'h18);
    chk("R4 R5 clear", status(), 32'h02);

    dequeue_with_push("R3 order B", 64'hE4E4);
    chk("R7 count kept", status(), 32'h02);
    dequeue("R3 order C");
    dequeue("R7 no loss E");
    chk("R6 drained", status(), 0);
    chk("R3 empty", head_valid, 0);

    wr(8'h0C, 4'hF, 32'h20);
    chk("R8 request on empty", status(), 32'h20);
    step();
    chk("R8 no change", status(), 0);

    wr(8'h0C, 4'hF, 32'hFFFF_FFC4);
    chk("R9 reserved write", status(), 0);
    push_frame(64'hF5F5);
    bus_addr = 8'h10; #1;
    chk("R9 other read", bus_rdata, 0);
    bus_addr = 8'h0C; #1;

    push_frame(64'h1616);
    push_frame(64'h2727);
    wr(8'h0C, 4'hF, 32'h08);
    chk("R4 cleared at 3", status(), 32'h03);
    dequeue_with_push("R3 order F", 64'h3838);
    chk("R7 full again", status(), 32'h0B);
    dequeue("R3 order G");
    dequeue("R3 order H");
    dequeue("R7 no loss I");
    chk("R2 final", status() & 32'h3, 0);
    finish_run();
  end
endmodule